// File: doc/BRIEF.md
# Write Protection and Cancel Controller

This block sits between the serial-bus front end of a small byte-wide nonvolatile memory and its array write engine. It decides whether a pending write may go ahead. It starts the internal write cycle, and it stops that cycle when protection demands it. Two protections are combined. The first is an external protect pin that, when high, guards the whole array. The second is a one-time lock flag that permanently guards the lower half of the address space. The lock is set by a completed write command sent to the protect-register device type. A separate input reports that the supply is too low for programming.

The front end reports command events to the block as single-cycle pulses. These are: a write command was addressed (memory or protect register), the first data bit of the first data byte was captured (the address is given with it), a stop began the commit, or the command was abandoned. The pin only counts from the first-data-bit event onward. Any high level seen from that event until the end of the write cycle cancels the write. A cancelled write drops busy at once, and the target data is left undefined. The block answers a protect-register selection with an acknowledge only while the lock is still clear.

Top module: `wprot_ctrl`

## Requirements
- R1: With the synchronized protect pin high at the commit, no array write strobe (`wr_en`) occurs, busy stays low and `abort_wr` pulses once.
- R2: Once the lock is set, a write whose address has its top bit 0 (the lower half) is refused with no strobe and one `abort_wr` pulse, whatever the pin level. A write with the top bit 1 and the pin low still completes.
- R3: A protect-register command that reaches the end of its write cycle sets the lock. Nothing but `rst` clears the lock afterwards, including further protect commands.
- R4: A protect-register selection (`cmd_sel` with `cmd_prot`=1) is answered with a one-cycle `prot_ack` while the lock is clear. After the lock is set it gets no `prot_ack`, and the rest of that command has no effect.
- R5: A protect pin high level that goes away before the first-data-bit event (`cmd_first`) has no effect, and the write completes in full.
- R6: The pin going high during the write cycle, or between `cmd_first` and the commit, ends the write. `busy` and `wr_en` fall on the same edge on which `abort_wr` pulses, after fewer than WR_CYCLES strobes.
- R7: `lv_inhibit` high refuses a write at the commit and ends a write cycle in progress, with one `abort_wr` pulse.
- R8: A permitted memory write holds `busy` and `wr_en` high for exactly WR_CYCLES cycles, starting the cycle after the `cmd_stop` pulse. A permitted protect write holds `busy` for WR_CYCLES cycles with no `wr_en`.
- R9: A refused write produces no `wr_en` cycle and no `busy` cycle.
- R10: `cmd_drop` before the commit abandons the command silently, with no strobe and no abort. The next command is handled normally.
- R11: After reset all outputs are low and the lock is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; also clears the lock |
| wp_pin | input | 1 | Asynchronous protect pin, high guards the whole array |
| lv_inhibit | input | 1 | High while the supply is below the programming threshold |
| cmd_sel | input | 1 | Pulse: a write command was addressed to this device |
| cmd_prot | input | 1 | With cmd_sel: 1 = protect-register type, 0 = memory type |
| cmd_first | input | 1 | Pulse: first data bit of the first data byte captured |
| cmd_addr | input | ADDR_W | Word address, valid with cmd_first |
| cmd_stop | input | 1 | Pulse: stop condition, commit the write |
| cmd_drop | input | 1 | Pulse: command abandoned before commit |
| wr_en | output | 1 | Array write strobe, high through a permitted memory write cycle |
| abort_wr | output | 1 | One-cycle pulse: the write was refused or cancelled |
| prot_ack | output | 1 | One-cycle acknowledge of a protect-register selection |
| busy | output | 1 | Internal write cycle in progress |

## Verification
Directed cases separate the pin's blind period from its cancel window. A pin pulse that ends before the first data bit must leave a full-length write. A pin rise between the first data bit and the stop, or during the cycle, must cut the write short with one abort. The low-voltage input is tried both at the commit and in mid-cycle. The lock is exercised before and after it is set, on both halves of the address space and with a repeated protect command, so that a lock guarding the wrong half, a lock that clears, or a lock that ignores the pin is told apart. Random commands with random pin, supply and address levels are then compared against a bench model of the lock, counting strobe, busy and abort cycles per command.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEL   = 2'd1,
    ST_ARMED = 2'd2,
    ST_CYCLE = 2'd3
  } wprot_state_e;

  // True when the lock forbids the target: the protect register itself,
  // or any address in the lower half of the array.
  function automatic logic lock_blocks(input logic locked,
                                       input logic to_prot,
                                       input logic addr_msb);
    return locked && (to_prot || !addr_msb);
  endfunction
endpackage

// File: rtl/wprot_sync.sv
module wprot_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/wprot_lock.sv
module wprot_lock (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  output logic locked
);
  // Set-only flag; reset stands for the blank state of a new part.
  always_ff @(posedge clk) begin
    if (rst)          locked <= 1'b0;
    else if (set_req) locked <= 1'b1;
  end
endmodule

// File: rtl/wprot_seq.sv
module wprot_seq
  import wprot_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int WR_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wp_s,
  input  logic              lv_inhibit,
  input  logic              locked,
  input  logic              cmd_sel,
  input  logic              cmd_prot,
  input  logic              cmd_first,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_stop,
  input  logic              cmd_drop,
  output logic              wr_en,
  output logic              abort_wr,
  output logic              prot_ack,
  output logic              busy,
  output logic              lock_set,
  output logic [ADDR_W-1:0] tgt_addr
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WR_CYCLES - 1);

  wprot_state_e     state;
  logic             tgt_prot;
  logic [CNT_W-1:0] cnt;
  logic             stop_now;

  assign stop_now = wp_s || lv_inhibit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      tgt_prot <= 1'b0;
      tgt_addr <= '0;
      cnt      <= '0;
      wr_en    <= 1'b0;
      busy     <= 1'b0;
      abort_wr <= 1'b0;
      prot_ack <= 1'b0;
      lock_set <= 1'b0;
    end else begin
      abort_wr <= 1'b0;
      prot_ack <= 1'b0;
      lock_set <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (cmd_sel) begin
            if (!cmd_prot) begin
              tgt_prot <= 1'b0;
              state    <= ST_SEL;
            end else if (!locked) begin
              tgt_prot <= 1'b1;
              prot_ack <= 1'b1;
              state    <= ST_SEL;
            end
          end
        end
        ST_SEL: begin
          // Pin level is deliberately not looked at here.
          if (cmd_drop) begin
            state <= ST_IDLE;
          end else if (cmd_first) begin
            tgt_addr <= cmd_addr;
            state    <= ST_ARMED;
          end
        end
        ST_ARMED: begin
          if (cmd_drop) begin
            state <= ST_IDLE;
          end else if (stop_now) begin
            abort_wr <= 1'b1;
            state    <= ST_IDLE;
          end else if (cmd_stop) begin
            if (lock_blocks(locked, tgt_prot, tgt_addr[ADDR_W-1])) begin
              abort_wr <= 1'b1;
              state    <= ST_IDLE;
            end else begin
              busy  <= 1'b1;
              wr_en <= !tgt_prot;
              cnt   <= '0;
              state <= ST_CYCLE;
            end
          end
        end
        ST_CYCLE: begin
          if (stop_now) begin
            abort_wr <= 1'b1;
            busy     <= 1'b0;
            wr_en    <= 1'b0;
            state    <= ST_IDLE;
          end else if (cnt == LAST) begin
            busy     <= 1'b0;
            wr_en    <= 1'b0;
            lock_set <= tgt_prot;
            state    <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl #(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int WR_CYCLES   = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wp_pin,
  input  logic              lv_inhibit,
  input  logic              cmd_sel,
  input  logic              cmd_prot,
  input  logic              cmd_first,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_stop,
  input  logic              cmd_drop,
  output logic              wr_en,
  output logic              abort_wr,
  output logic              prot_ack,
  output logic              busy
);
  logic              wp_s;
  logic              locked;
  logic              lock_set;
  logic [ADDR_W-1:0] tgt_addr;

  wprot_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(wp_pin), .dout(wp_s)
  );

  wprot_lock u_lock (
    .clk(clk), .rst(rst), .set_req(lock_set), .locked(locked)
  );

  wprot_seq #(.ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .wp_s(wp_s), .lv_inhibit(lv_inhibit),
    .locked(locked), .cmd_sel(cmd_sel), .cmd_prot(cmd_prot),
    .cmd_first(cmd_first), .cmd_addr(cmd_addr), .cmd_stop(cmd_stop),
    .cmd_drop(cmd_drop), .wr_en(wr_en), .abort_wr(abort_wr),
    .prot_ack(prot_ack), .busy(busy), .lock_set(lock_set),
    .tgt_addr(tgt_addr)
  );
endmodule

// File: rtl/wprot_ctrl_chk.sv
module wprot_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic wp_s,
  input logic lv_inhibit,
  input logic locked,
  input logic addr_msb,
  input logic wr_en,
  input logic busy,
  input logic abort_wr,
  input logic prot_ack
);
  a_r3_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    $past(locked) |-> locked);

  a_r1_pin_stops_strobe: assert property (@(posedge clk) disable iff (rst)
    (busy && wp_s) |=> !wr_en);

  a_r7_low_supply_ends_cycle: assert property (@(posedge clk) disable iff (rst)
    (busy && lv_inhibit) |=> !busy);

  a_r6_abort_drops_busy: assert property (@(posedge clk) disable iff (rst)
    abort_wr |-> (!busy && !wr_en));

  a_r6_abort_single: assert property (@(posedge clk) disable iff (rst)
    abort_wr |=> !abort_wr);

  a_r8_strobe_inside_busy: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> busy);

  a_r2_lower_half_locked: assert property (@(posedge clk) disable iff (rst)
    (wr_en && locked) |-> addr_msb);

  a_r4_no_ack_when_locked: assert property (@(posedge clk) disable iff (rst)
    prot_ack |-> !locked);
endmodule

bind wprot_ctrl wprot_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .wp_s(wp_s), .lv_inhibit(lv_inhibit),
  .locked(locked), .addr_msb(tgt_addr[ADDR_W-1]), .wr_en(wr_en),
  .busy(busy), .abort_wr(abort_wr), .prot_ack(prot_ack)
);

// File: tb/wprot_ctrl_tb.sv
module wprot_ctrl_tb;
  localparam int AW  = 8;
  localparam int SYN = 2;
  localparam int WRC = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wp_pin = 1'b0, lv_inhibit = 1'b0;
  logic cmd_sel = 1'b0, cmd_prot = 1'b0, cmd_first = 1'b0;
  logic cmd_stop = 1'b0, cmd_drop = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic wr_en, abort_wr, prot_ack, busy;

  int n_chk = 0, n_fail = 0;
  int strobe_cnt = 0, abort_cnt = 0, busy_cnt = 0;
  bit lock_m = 1'b0;

  always #4 clk = ~clk;

  wprot_ctrl #(.ADDR_W(AW), .SYNC_STAGES(SYN), .WR_CYCLES(WRC)) u_dut (
    .clk(clk), .rst(rst), .wp_pin(wp_pin), .lv_inhibit(lv_inhibit),
    .cmd_sel(cmd_sel), .cmd_prot(cmd_prot), .cmd_first(cmd_first),
    .cmd_addr(cmd_addr), .cmd_stop(cmd_stop), .cmd_drop(cmd_drop),
    .wr_en(wr_en), .abort_wr(abort_wr), .prot_ack(prot_ack), .busy(busy)
  );

  always @(posedge clk) begin
    if (wr_en)    strobe_cnt <= strobe_cnt + 1;
    if (abort_wr) abort_cnt  <= abort_cnt + 1;
    if (busy)     busy_cnt   <= busy_cnt + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_sel(input bit p, output bit ack);
    @(negedge clk); cmd_sel = 1'b1; cmd_prot = p;
    @(negedge clk); cmd_sel = 1'b0; cmd_prot = 1'b0; ack = prot_ack;
  endtask

  task automatic do_first(input logic [AW-1:0] a);
    @(negedge clk); cmd_first = 1'b1; cmd_addr = a;
    @(negedge clk); cmd_first = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk); cmd_stop = 1'b1;
    @(negedge clk); cmd_stop = 1'b0;
  endtask

  task automatic do_drop();
    @(negedge clk); cmd_drop = 1'b1;
    @(negedge clk); cmd_drop = 1'b0;
  endtask

  // Full command with levels held steady; deltas of strobe/abort/busy cycles.
  task automatic txn(input bit p, input logic [AW-1:0] a,
                     output int st, output int ab, output int bz, output bit ack);
    int s0, a0, b0;
    s0 = strobe_cnt; a0 = abort_cnt; b0 = busy_cnt;
    do_sel(p, ack);
    do_first(a);
    do_stop();
    wait_cyc(WRC + 4);
    st = strobe_cnt - s0; ab = abort_cnt - a0; bz = busy_cnt - b0;
  endtask

  function automatic int exp_strobes(bit p, logic [AW-1:0] a, bit wp, bit lv, bit lk);
    if (p || wp || lv || (lk && !a[AW-1])) return 0;
    return WRC;
  endfunction

  function automatic bit exp_allowed(bit p, logic [AW-1:0] a, bit wp, bit lv, bit lk);
    return !wp && !lv && !(lk && (p || !a[AW-1]));
  endfunction

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int st, ab, bz, s0, a0;
    bit ack;
    void'($urandom(32'd1234));
    wait_cyc(4);
    // R11: outputs low during and after reset
    chk("R11 wr_en in reset", wr_en, 0);
    chk("R11 busy in reset", busy, 0);
    @(negedge clk); rst = 1'b0;
    wait_cyc(2);
    chk("R11 abort after reset", abort_wr, 0);
    chk("R11 prot_ack after reset", prot_ack, 0);

    // R8: plain memory write
    txn(1'b0, 8'h12, st, ab, bz, ack);
    chk("R8 strobes", st, WRC);
    chk("R8 busy cycles", bz, WRC);
    chk("R8 no abort", ab, 0);
    // R8: busy visible the cycle after stop
    do_sel(1'b0, ack); do_first(8'h90);
    @(negedge clk); cmd_stop = 1'b1;
    @(negedge clk); cmd_stop = 1'b0;
    chk("R8 busy after stop", busy, 1);
    chk("R8 wr_en after stop", wr_en, 1);
    wait_cyc(WRC + 4);

    // R1 / R9: pin held high
    wp_pin = 1'b1; wait_cyc(SYN + 2);
    txn(1'b0, 8'hA0, st, ab, bz, ack);
    chk("R1 strobes with pin high", st, 0);
    chk("R1 abort with pin high", ab, 1);
    chk("R9 busy with pin high", bz, 0);
    wp_pin = 1'b0; wait_cyc(SYN + 2);

    // R7: low supply at commit
    lv_inhibit = 1'b1;
    txn(1'b0, 8'hC3, st, ab, bz, ack);
    chk("R7 strobes low supply", st, 0);
    chk("R7 abort low supply", ab, 1);
    chk("R9 busy low supply", bz, 0);
    lv_inhibit = 1'b0;

    // R5: pin pulse ending before first data bit is ignored
    s0 = strobe_cnt; a0 = abort_cnt;
    wp_pin = 1'b1; wait_cyc(SYN + 2);
    do_sel(1'b0, ack);
    wp_pin = 1'b0; wait_cyc(SYN + 2);
    do_first(8'h44); do_stop(); wait_cyc(WRC + 4);
    chk("R5 strobes after early pin pulse", strobe_cnt - s0, WRC);
    chk("R5 no abort", abort_cnt - a0, 0);

    // R6: pin rises between first data bit and stop
    s0 = strobe_cnt; a0 = abort_cnt;
    do_sel(1'b0, ack); do_first(8'h45);
    wp_pin = 1'b1; wait_cyc(SYN + 2);
    do_stop(); wait_cyc(WRC + 4);
    chk("R6 strobes pin in window", strobe_cnt - s0, 0);
    chk("R6 abort pin in window", abort_cnt - a0, 1);
    wp_pin = 1'b0; wait_cyc(SYN + 2);

    // R6: pin rises mid-cycle
    s0 = strobe_cnt; a0 = abort_cnt;
    do_sel(1'b0, ack); do_first(8'h46); do_stop();
    wait_cyc(10);
    wp_pin = 1'b1; wait_cyc(SYN + 3);
    chk("R6 busy low after cancel", busy, 0);
    chk("R6 wr_en low after cancel", wr_en, 0);
    chk("R6 abort count mid-cycle", abort_cnt - a0, 1);
    chk("R6 strobes cut short", ((strobe_cnt - s0) > 0 && (strobe_cnt - s0) < WRC) ? 1 : 0, 1);
    wp_pin = 1'b0; wait_cyc(SYN + 2);

    // R7: low supply mid-cycle
    s0 = strobe_cnt; a0 = abort_cnt;
    do_sel(1'b0, ack); do_first(8'h47); do_stop();
    wait_cyc(6);
    lv_inhibit = 1'b1; wait_cyc(3); lv_inhibit = 1'b0;
    chk("R7 busy low mid-cycle", busy, 0);
    chk("R7 abort mid-cycle", abort_cnt - a0, 1);
    chk("R7 strobes cut short", ((strobe_cnt - s0) < WRC) ? 1 : 0, 1);

    // R10: abandoned commands
    s0 = strobe_cnt; a0 = abort_cnt;
    do_sel(1'b0, ack); do_drop(); do_first(8'h10); do_stop(); wait_cyc(4);
    do_sel(1'b0, ack); do_first(8'h11); do_drop(); do_stop(); wait_cyc(WRC + 4);
    chk("R10 strobes after drop", strobe_cnt - s0, 0);
    chk("R10 abort after drop", abort_cnt - a0, 0);
    txn(1'b0, 8'h12, st, ab, bz, ack);
    chk("R10 next write normal", st, WRC);

    // R4 / R3: protect command while pin high is refused, lock stays clear
    wp_pin = 1'b1; wait_cyc(SYN + 2);
    txn(1'b1, 8'h00, st, ab, bz, ack);
    chk("R4 ack before lock", ack, 1);
    chk("R3 refused protect abort", ab, 1);
    wp_pin = 1'b0; wait_cyc(SYN + 2);
    txn(1'b0, 8'h05, st, ab, bz, ack);
    chk("R3 lower half open while unlocked", st, WRC);

    // R3: set lock
    txn(1'b1, 8'h00, st, ab, bz, ack);
    chk("R4 ack unlocked", ack, 1);
    chk("R8 protect busy cycles", bz, WRC);
    chk("R8 protect no strobes", st, 0);
    lock_m = 1'b1;

    // R2: lower half refused, upper half open
    txn(1'b0, 8'h7F, st, ab, bz, ack);
    chk("R2 lower half refused", st, 0);
    chk("R2 lower half abort", ab, 1);
    chk("R9 lower half busy", bz, 0);
    txn(1'b0, 8'h80, st, ab, bz, ack);
    chk("R2 upper half allowed", st, WRC);
    wp_pin = 1'b1; wait_cyc(SYN + 2);
    txn(1'b0, 8'hF0, st, ab, bz, ack);
    chk("R2 upper half with pin high", st, 0);
    wp_pin = 1'b0; wait_cyc(SYN + 2);

    // R4 / R3: locked protect command not acked and without effect
    txn(1'b1, 8'h00, st, ab, bz, ack);
    chk("R4 no ack when locked", ack, 0);
    chk("R4 locked protect no busy", bz, 0);
    chk("R4 locked protect no abort", ab, 0);
    txn(1'b0, 8'h01, st, ab, bz, ack);
    chk("R3 lock still set", st, 0);

    // Random phase: fresh part, model-checked
    @(negedge clk); rst = 1'b1; wait_cyc(2); rst = 1'b0; lock_m = 1'b0;
    wait_cyc(2);
    for (int i = 0; i < 40; i++) begin
      bit p, wp, lv, al;
      logic [AW-1:0] a;
      p  = ($urandom % 8) == 0;
      wp = ($urandom % 4) == 0;
      lv = ($urandom % 6) == 0;
      a  = AW'($urandom);
      wp_pin = wp; lv_inhibit = lv; wait_cyc(SYN + 2);
      txn(p, a, st, ab, bz, ack);
      if (p && lock_m) begin
        chk("R4 random locked ack", ack, 0);
        chk("R4 random locked strobes", st, 0);
        chk("R4 random locked abort", ab, 0);
      end else begin
        al = exp_allowed(p, a, wp, lv, lock_m);
        if (p) chk("R4 random ack", ack, 1);
        chk("R2 random strobes", st, exp_strobes(p, a, wp, lv, lock_m));
        chk("R1 random abort", ab, al ? 0 : 1);
        chk("R9 random busy", bz, al ? WRC : 0);
        if (p && al) lock_m = 1'b1;
      end
    end
    wp_pin = 1'b0; lv_inhibit = 1'b0;
    wait_cyc(4);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule